// File: doc/BRIEF.md
# Legacy IDE I/O Port Decoder

This block turns host I/O-space accesses into register selects for the two channels of an IDE controller that runs in legacy (compatibility) mode. Each channel has two fixed windows in I/O space. The first is an eight-byte command block that holds the task-file registers. The second is a single control byte that reads as device status and writes as device control. The decoder looks at the address and the access size and produces a hit flag, which the surrounding bus logic uses to claim the cycle. It also produces the channel number, the task-file register index, a control-byte select and a data-port select. The read and write strobes come out qualified by the hit flag.

Each channel can be switched between legacy and native addressing. A per-channel enable bit reflects that choice, and a channel whose bit is clear claims nothing. For reads, the block picks the selecting channel's data and trims it to the access width. A read that misses every window returns all ones. The decode is purely combinational and holds no state.

Top module: `ide_legacy_decode`

## Requirements
- R1: With `legacy_en[0]` set, a byte access (`io_size` = 0) at 0x1F0..0x1F7 gives `hit`=1, `chan_sel`=0, `reg_idx` = address minus 0x1F0, `ctrl_sel`=0 and `data_sel`=0.
- R2: With `legacy_en[1]` set, a byte access at 0x170..0x177 gives `hit`=1, `chan_sel`=1, `reg_idx` = address minus 0x170, `ctrl_sel`=0 and `data_sel`=0.
- R3: A byte access at 0x3F6 (channel 0) or 0x376 (channel 1), with that channel enabled, gives `hit`=1, `ctrl_sel`=1, `data_sel`=0, `reg_idx`=0 and `chan_sel` equal to the channel.
- R4: A 16-bit (`io_size` = 1) or 32-bit (`io_size` = 2) access at exactly 0x1F0 or 0x170, with that channel enabled, gives `hit`=1, `data_sel`=1, `reg_idx`=0, `ctrl_sel`=0 and `chan_sel` equal to the channel.
- R5: A wide access at a nonzero command-block offset, a wide access to a control byte, and any access with the reserved size code 3 all give `hit`=0.
- R6: When a channel's `legacy_en` bit is clear, no access to either of that channel's windows hits, whatever the size.
- R7: `rd_strobe` equals `io_rd` and `wr_strobe` equals `io_wr` during a hit, and both are 0 when there is no hit.
- R8: `rdata` is all ones on a miss. On a control-byte hit it is the channel's status byte, zero-extended. On a command hit it is the channel's `cmd_rdata` lane, cut to 8, 16 or 32 bits by the size and zero-extended.
- R9: Every address outside the four windows misses, including addresses that match a window in the low ten bits only. On a miss, `chan_sel`, `reg_idx`, `ctrl_sel` and `data_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_addr | input | 16 | I/O address of the current access |
| io_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| legacy_en | input | 2 | Per-channel legacy decode enable, bit 0 primary, bit 1 secondary |
| cmd_rdata | input | 64 | Per-channel command-block read data, channel 0 in bits 31:0 |
| status_in | input | 16 | Per-channel device status byte, channel 0 in bits 7:0 |
| hit | output | 1 | The access falls in an enabled, legal window |
| chan_sel | output | 1 | Channel of the hit, 0 primary, 1 secondary |
| reg_idx | output | 3 | Task-file register index for command-block byte accesses |
| ctrl_sel | output | 1 | The control/status byte is selected |
| data_sel | output | 1 | A wide access to the data port is selected |
| rd_strobe | output | 1 | Read strobe qualified by the hit |
| wr_strobe | output | 1 | Write strobe qualified by the hit |
| rdata | output | 32 | Read data returned to the host |

## Verification
The embedded assertions enforce invariants that hold on every evaluation. At most one window may hit at a time. A disabled configuration and the reserved size never hit. Strobes appear only with a hit. The data-port select only goes with a wide access at index zero, and the control select only with byte accesses. Whether each hit lands on the correct channel and register index, the exact edge addresses of every window, and the read-data width trimming can only be shown by the bench's sweep. That sweep covers every address below 0x400, together with aliased high addresses, under all sizes, enable combinations and strobe patterns.

// File: rtl/ide_leg_pkg.sv
package ide_leg_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } io_size_e;

  localparam int unsigned NUM_CHAN      = 2;
  localparam int unsigned CMD_SPAN_LOG2 = 3;
  localparam int unsigned IDX_W         = 3;
  localparam int unsigned STATUS_W      = 8;

endpackage

// File: rtl/ide_leg_window.sv
module ide_leg_window #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE      = 0,
  parameter int unsigned SPAN_LOG2 = 0,
  parameter int unsigned OFF_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  output logic              match,
  output logic [OFF_W-1:0]  offset
);

  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

  generate
    if (SPAN_LOG2 == 0) begin : g_single
      assign match  = en && (addr == BASE_V);
      assign offset = '0;
    end else begin : g_span
      assign match  = en && (addr[ADDR_W-1:SPAN_LOG2] == BASE_V[ADDR_W-1:SPAN_LOG2]);
      assign offset = OFF_W'(addr[SPAN_LOG2-1:0]);
    end
  endgenerate

  always_comb begin
    if (!en) AST_WINDOW_GATED: assert (!match); // R6
  end

endmodule

// File: rtl/ide_leg_size_check.sv
module ide_leg_size_check
  import ide_leg_pkg::*;
#(
  parameter int unsigned OFF_W = 3
) (
  input  logic [1:0]       size,
  input  logic             cmd_match,
  input  logic [OFF_W-1:0] cmd_offset,
  input  logic             ctl_match,
  output logic             cmd_byte_ok,
  output logic             data_ok,
  output logic             ctl_ok
);

  always_comb begin
    cmd_byte_ok = 1'b0;
    data_ok     = 1'b0;
    ctl_ok      = 1'b0;
    unique case (io_size_e'(size))
      SZ_BYTE: begin
        cmd_byte_ok = cmd_match;
        ctl_ok      = ctl_match;
      end
      SZ_WORD, SZ_DWORD: begin
        data_ok = cmd_match && (cmd_offset == '0);
      end
      default: ;
    endcase
  end

  always_comb begin
    if (data_ok) AST_WIDE_AT_ZERO: assert (cmd_offset == '0 && size != 2'd0); // R4
    if (ctl_ok)  AST_CTRL_NARROW:  assert (size == 2'd0);                     // R5
  end

endmodule

// File: rtl/ide_leg_rdata.sv
module ide_leg_rdata
  import ide_leg_pkg::*;
#(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic                       hit,
  input  logic [$clog2(N_CH)-1:0]    chan,
  input  logic                       ctrl_sel,
  input  logic [1:0]                 size,
  input  logic [N_CH*DATA_W-1:0]     cmd_rdata,
  input  logic [N_CH*STATUS_W-1:0]   status_in,
  output logic [DATA_W-1:0]          rdata
);

  logic [DATA_W-1:0]   lane;
  logic [STATUS_W-1:0] stat;

  assign lane = cmd_rdata[chan*DATA_W +: DATA_W];
  assign stat = status_in[chan*STATUS_W +: STATUS_W];

  always_comb begin
    if (!hit) begin
      rdata = '1;
    end else if (ctrl_sel) begin
      rdata = DATA_W'(stat);
    end else begin
      unique case (io_size_e'(size))
        SZ_BYTE: rdata = DATA_W'(lane[7:0]);
        SZ_WORD: rdata = DATA_W'(lane[15:0]);
        default: rdata = lane;
      endcase
    end
  end

  always_comb begin
    if (hit && size == 2'd0) AST_BYTE_UPPER_ZERO: assert (rdata[DATA_W-1:8] == '0); // R8
  end

endmodule

// File: rtl/ide_legacy_decode.sv
module ide_legacy_decode
  import ide_leg_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned PRI_CMD_BASE = 32'h01F0,
  parameter int unsigned SEC_CMD_BASE = 32'h0170,
  parameter int unsigned PRI_CTL_BASE = 32'h03F6,
  parameter int unsigned SEC_CTL_BASE = 32'h0376
) (
  input  logic [ADDR_W-1:0]            io_addr,
  input  logic [1:0]                   io_size,
  input  logic                         io_rd,
  input  logic                         io_wr,
  input  logic [NUM_CHAN-1:0]          legacy_en,
  input  logic [NUM_CHAN*DATA_W-1:0]   cmd_rdata,
  input  logic [NUM_CHAN*STATUS_W-1:0] status_in,
  output logic                         hit,
  output logic                         chan_sel,
  output logic [IDX_W-1:0]             reg_idx,
  output logic                         ctrl_sel,
  output logic                         data_sel,
  output logic                         rd_strobe,
  output logic                         wr_strobe,
  output logic [DATA_W-1:0]            rdata
);

  localparam int unsigned CH_W = $clog2(NUM_CHAN);

  logic [NUM_CHAN-1:0]  cmd_match, ctl_match;
  logic [NUM_CHAN-1:0]  cmd_byte_ok, data_ok, ctl_ok;
  logic [IDX_W-1:0]     cmd_off [NUM_CHAN];
  logic [IDX_W-1:0]     ctl_off [NUM_CHAN];

  generate
    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
      localparam int unsigned CMD_B = (ch == 0) ? PRI_CMD_BASE : SEC_CMD_BASE;
      localparam int unsigned CTL_B = (ch == 0) ? PRI_CTL_BASE : SEC_CTL_BASE;

      ide_leg_window #(
        .ADDR_W(ADDR_W), .BASE(CMD_B), .SPAN_LOG2(CMD_SPAN_LOG2), .OFF_W(IDX_W)
      ) i_cmd_win (
        .addr(io_addr), .en(legacy_en[ch]),
        .match(cmd_match[ch]), .offset(cmd_off[ch])
      );

      ide_leg_window #(
        .ADDR_W(ADDR_W), .BASE(CTL_B), .SPAN_LOG2(0), .OFF_W(IDX_W)
      ) i_ctl_win (
        .addr(io_addr), .en(legacy_en[ch]),
        .match(ctl_match[ch]), .offset(ctl_off[ch])
      );

      ide_leg_size_check #(.OFF_W(IDX_W)) i_size (
        .size(io_size), .cmd_match(cmd_match[ch]), .cmd_offset(cmd_off[ch]),
        .ctl_match(ctl_match[ch]), .cmd_byte_ok(cmd_byte_ok[ch]),
        .data_ok(data_ok[ch]), .ctl_ok(ctl_ok[ch])
      );
    end
  endgenerate

  logic [CH_W-1:0] chan_w;

  always_comb begin
    hit      = 1'b0;
    chan_w   = '0;
    reg_idx  = '0;
    ctrl_sel = 1'b0;
    data_sel = 1'b0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (cmd_byte_ok[c] || data_ok[c] || ctl_ok[c]) begin
        hit      = 1'b1;
        chan_w   = CH_W'(c);
        ctrl_sel = ctl_ok[c];
        data_sel = data_ok[c];
        reg_idx  = cmd_byte_ok[c] ? cmd_off[c] : ctl_off[c];
      end
    end
  end

  assign chan_sel  = chan_w[0];
  assign rd_strobe = io_rd & hit;
  assign wr_strobe = io_wr & hit;

  ide_leg_rdata #(.N_CH(NUM_CHAN), .DATA_W(DATA_W)) i_rdata (
    .hit(hit), .chan(chan_w), .ctrl_sel(ctrl_sel), .size(io_size),
    .cmd_rdata(cmd_rdata), .status_in(status_in), .rdata(rdata)
  );

  always_comb begin
    AST_ONE_WINDOW: assert ($onehot0({cmd_byte_ok, data_ok, ctl_ok})); // R9
    if (legacy_en == '0) AST_DISABLED_SILENT: assert (!hit);           // R6
    if (io_size == 2'd3) AST_RSVD_SIZE_MISS: assert (!hit);            // R5
    if (rd_strobe || wr_strobe) AST_STROBE_QUAL: assert (hit);         // R7
    if (data_sel) AST_DATA_IDX_ZERO: assert (reg_idx == '0 && !ctrl_sel); // R4
    if (ctrl_sel) AST_CTRL_IDX: assert (reg_idx == '0 && io_size == 2'd0); // R3
  end

endmodule

// File: tb/test_ide_legacy_decode.sv
module test_ide_legacy_decode;

  logic        clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [1:0]  legacy_en = '0;
  logic [63:0] cmd_rdata = '0;
  logic [15:0] status_in = '0;
  logic        hit, chan_sel, ctrl_sel, data_sel, rd_strobe, wr_strobe;
  logic [2:0]  reg_idx;
  logic [31:0] rdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  ide_legacy_decode i_ide_legacy_decode (
    .io_addr(io_addr), .io_size(io_size), .io_rd(io_rd), .io_wr(io_wr),
    .legacy_en(legacy_en), .cmd_rdata(cmd_rdata), .status_in(status_in),
    .hit(hit), .chan_sel(chan_sel), .reg_idx(reg_idx), .ctrl_sel(ctrl_sel),
    .data_sel(data_sel), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .rdata(rdata)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s addr=%h size=%0d en=%b actual=%h expected=%h",
               tag, what, io_addr, io_size, legacy_en, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // reset state: idle bus, nothing enabled -> no hit, all-ones read (R9, R8)
    @(posedge clk);
    @(negedge clk);
    check(hit == 1'b0 && reg_idx == 3'd0, "R9", "idle decode",
          {31'd0, hit}, 32'd0);
    check(rdata == 32'hFFFF_FFFF, "R8", "idle rdata", rdata, 32'hFFFF_FFFF);

    for (int k = 0; k < 1028; k++) begin
      logic [15:0] a;
      case (k)
        1024:    a = 16'h11F0;
        1025:    a = 16'h8376;
        1026:    a = 16'hFDF6;
        1027:    a = 16'h0570;
        default: a = 16'(k);
      endcase
      for (int sz = 0; sz < 4; sz++) begin
        for (int en = 0; en < 4; en++) begin
          for (int op = 0; op < 3; op++) begin
            bit          e_hit, e_ch, e_ctl, e_dat;
            logic [2:0]  e_idx;
            logic [31:0] e_rd, c0, c1;
            logic [7:0]  s0, s1;
            string       tag;
            c0 = 32'hA1B2_C3D4 ^ {16'h0, a};
            c1 = 32'h9E8F_7061 ^ {a, 16'h0};
            s0 = 8'h50 ^ a[7:0];
            s1 = 8'h41 ^ a[9:2];
            @(posedge clk);
            io_addr   = a;
            io_size   = 2'(sz);
            legacy_en = 2'(en);
            io_rd     = (op == 0);
            io_wr     = (op == 1);
            cmd_rdata = {c1, c0};
            status_in = {s1, s0};
            e_hit = 0; e_ch = 0; e_ctl = 0; e_dat = 0; e_idx = 0;
            tag = "R9";
            for (int ch = 0; ch < 2; ch++) begin
              int cb, tb;
              cb = (ch == 0) ? 16'h01F0 : 16'h0170;
              tb = (ch == 0) ? 16'h03F6 : 16'h0376;
              if ((int'(a) >> 3) == (cb >> 3)) begin
                if (((en >> ch) & 1) == 0) tag = "R6";
                else if (sz == 0) begin
                  e_hit = 1; e_ch = ch[0]; e_idx = 3'(int'(a) - cb);
                  tag = (ch == 0) ? "R1" : "R2";
                end else if ((sz == 1 || sz == 2) && int'(a) == cb) begin
                  e_hit = 1; e_ch = ch[0]; e_dat = 1; tag = "R4";
                end else tag = "R5";
              end
              if (int'(a) == tb) begin
                if (((en >> ch) & 1) == 0) tag = "R6";
                else if (sz == 0) begin
                  e_hit = 1; e_ch = ch[0]; e_ctl = 1; tag = "R3";
                end else tag = "R5";
              end
            end
            if (!e_hit) e_rd = 32'hFFFF_FFFF;
            else if (e_ctl) e_rd = {24'd0, e_ch ? s1 : s0};
            else begin
              logic [31:0] ln;
              ln = e_ch ? c1 : c0;
              e_rd = (sz == 0) ? {24'd0, ln[7:0]} :
                     (sz == 1) ? {16'd0, ln[15:0]} : ln;
            end
            @(negedge clk);
            check({hit, chan_sel, reg_idx, ctrl_sel, data_sel} ==
                  {e_hit, e_ch, e_idx, e_ctl, e_dat}, tag, "decode",
                  {25'd0, hit, chan_sel, reg_idx, ctrl_sel, data_sel},
                  {25'd0, e_hit, e_ch, e_idx, e_ctl, e_dat});
            check(rd_strobe == ((op == 0) && e_hit) && wr_strobe == ((op == 1) && e_hit),
                  "R7", "strobes", {30'd0, rd_strobe, wr_strobe},
                  {30'd0, (op == 0) && e_hit, (op == 1) && e_hit});
            check(rdata == e_rd, "R8", "rdata", rdata, e_rd);
          end
        end
      end
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule